// File: doc/BRIEF.md
# Loadable Bus Register with Shared-Enable Tri-State Output

This block is a small storage register that hangs off a shared tri-state data bus. On a rising clock edge it copies the word on the bus into its storage, but only while its load strobe is high. With the strobe low, clock edges leave the stored word alone.

Two asynchronous overrides force the whole word. Clear forces every bit to 0 and preset forces every bit to 1, and clear wins when both are asserted. The stored word is available at all times as a true output and as a bitwise complemented output.

One drive enable switches all output drivers together. When it is high, the stored word is placed on the bus. When it is low, every bus line is released so that another agent can drive it. A surrounding sequencer must never raise load while nobody drives the bus, because a floating line reads as an arbitrary value.

Top module: `bus_register`

## Requirements
- R1: With load_i at 1 and neither override asserted, the word on bus_io at a rising edge of clk_i appears on q_o right after that edge.
- R2: With load_i at 0 and neither override asserted, q_o keeps its value across a rising clock edge, whatever bus_io carries.
- R3: Asserting clear_i sets q_o to all zeros at once, with no clock edge needed, and holds it there across clock edges even when load_i is 1.
- R4: Asserting preset_i while clear_i is 0 sets q_o to all ones at once, with no clock edge needed, and holds it there across clock edges even when load_i is 1.
- R5: When clear_i and preset_i are both 1, q_o is all zeros.
- R6: q_n_o is always the bitwise complement of q_o.
- R7: With drive_en_i at 1, every line of bus_io carries the matching bit of q_o.
- R8: With drive_en_i at 0, the register drives no line of bus_io, so a value driven by another agent appears on the bus unaltered and can be captured through R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Capture clock, rising edge |
| load_i | input | 1 | Capture gate, active high |
| clear_i | input | 1 | Asynchronous force to zero, active high, wins over preset |
| preset_i | input | 1 | Asynchronous force to ones, active high |
| drive_en_i | input | 1 | Common enable for all bus drivers |
| bus_io | inout | WIDTH (4) | Shared tri-state data bus |
| q_o | output | WIDTH (4) | Stored word |
| q_n_o | output | WIDTH (4) | Complement of the stored word |

## Verification
A bus capture is due on q_o and q_n_o in the same cycle as the rising edge that sampled it. There is one register stage and no pipeline, so the bench drives inputs at a falling edge, moves its model at the following rising edge, and compares at the next falling edge. The overrides and the bus drive do not wait for a clock at all. For these, the bench changes the input in the middle of a low phase and compares one time unit later, before any edge arrives. The bus is compared only while exactly one agent drives it.

// File: rtl/bus_register_pkg.sv
package bus_register_pkg;

  // Priority of the per-bit next state: clear, then preset, then load, else hold.
  function automatic logic bit_next(input logic clr, input logic pre,
                                    input logic ld, input logic d,
                                    input logic q);
    if (clr)      return 1'b0;
    else if (pre) return 1'b1;
    else if (ld)  return d;
    else          return q;
  endfunction

endpackage

// File: rtl/bus_register_cell.sv
module bus_register_cell
  import bus_register_pkg::*;
(
  input  logic clk_i,
  input  logic clear_i,
  input  logic preset_i,
  input  logic load_i,
  input  logic d_i,
  output logic q_o
);

  logic cap_next;

  // Synchronous path only; overrides are handled asynchronously below.
  assign cap_next = bit_next(1'b0, 1'b0, load_i, d_i, q_o);

  always_ff @(posedge clk_i or posedge clear_i or posedge preset_i) begin
    if (clear_i)       q_o <= 1'b0;
    else if (preset_i) q_o <= 1'b1;
    else               q_o <= cap_next;
  end

endmodule

// File: rtl/bus_register_outdrv.sv
module bus_register_outdrv #(
  parameter int WIDTH = 4
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] word_i,
  output logic [WIDTH-1:0] drv_val_o,
  output logic [WIDTH-1:0] drv_en_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    assign drv_val_o[g] = word_i[g];
    assign drv_en_o[g]  = en_i;
  end

endmodule

// File: rtl/bus_register.sv
module bus_register #(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             load_i,
  input  logic             clear_i,
  input  logic             preset_i,
  input  logic             drive_en_i,
  inout  wire  [WIDTH-1:0] bus_io,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] q_n_o
);

  logic [WIDTH-1:0] stored;
  logic [WIDTH-1:0] drv_val;
  logic [WIDTH-1:0] drv_en;

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    bus_register_cell u_cell (
      .clk_i   (clk_i),
      .clear_i (clear_i),
      .preset_i(preset_i),
      .load_i  (load_i),
      .d_i     (bus_io[g]),
      .q_o     (stored[g])
    );
    assign bus_io[g] = drv_en[g] ? drv_val[g] : 1'bz;
  end

  bus_register_outdrv #(.WIDTH(WIDTH)) u_drv (
    .en_i     (drive_en_i),
    .word_i   (stored),
    .drv_val_o(drv_val),
    .drv_en_o (drv_en)
  );

  assign q_o   = stored;
  assign q_n_o = ~stored;

endmodule

// File: rtl/bus_register_chk.sv
module bus_register_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             load_i,
  input logic             clear_i,
  input logic             preset_i,
  input logic             drive_en_i,
  input logic [WIDTH-1:0] bus_io,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] q_n_o
);

  logic ovr;
  assign ovr = clear_i || preset_i;

  p_capture_r1: assert property (@(posedge clk_i) disable iff (ovr)
    load_i |=> (q_o == $past(bus_io)));

  p_hold_r2: assert property (@(posedge clk_i) disable iff (ovr)
    !load_i |=> $stable(q_o));

  // R3 and R5: clear yields zeros, also when preset is high.
  p_clear_r3: assert property (@(posedge clk_i)
    clear_i |-> (q_o == '0));

  p_preset_r4: assert property (@(posedge clk_i)
    (preset_i && !clear_i) |-> (q_o == '1));

  p_complement_r6: assert property (@(posedge clk_i)
    (q_n_o == ~q_o));

  p_drive_r7: assert property (@(posedge clk_i) disable iff (ovr)
    drive_en_i |-> (bus_io == q_o));

endmodule

bind bus_register bus_register_chk #(.WIDTH(WIDTH)) u_chk (
  .clk_i     (clk_i),
  .load_i    (load_i),
  .clear_i   (clear_i),
  .preset_i  (preset_i),
  .drive_en_i(drive_en_i),
  .bus_io    (bus_io),
  .q_o       (q_o),
  .q_n_o     (q_n_o)
);

// File: tb/bus_register_test.sv
module bus_register_test;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       load = 1'b0;
  logic       clr = 1'b1;
  logic       pre = 1'b0;
  logic       den = 1'b0;
  logic       oen = 1'b0;
  logic [3:0] oval = 4'h0;
  wire  [3:0] bus;
  logic [3:0] q, qn;

  int checks = 0;
  int fails  = 0;
  int model  = 0;
  bit done   = 1'b0;

  assign bus = oen ? oval : 4'bzzzz;

  bus_register #(.WIDTH(4)) uut (
    .clk_i(clk), .load_i(load), .clear_i(clr), .preset_i(pre),
    .drive_en_i(den), .bus_io(bus), .q_o(q), .q_n_o(qn)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Compare all outputs against the model; bus compared when one agent drives.
  task automatic compare(input string req);
    chk(req, q, model[3:0]);
    chk("R6", qn, ~model[3:0]);
    if (den && !oen) chk("R7", bus, model[3:0]);
    if (oen && !den) chk("R8", bus, oval);
  endtask

  // Drive at a falling edge, model steps at the rising edge, compare at next falling edge.
  task automatic step(input string req, input logic l, input logic c, input logic p,
                      input logic d, input logic o, input logic [3:0] v);
    logic [3:0] busexp;
    @(negedge clk);
    load = l; clr = c; pre = p; den = d; oen = o; oval = v;
    busexp = o ? v : model[3:0];
    @(posedge clk);
    if (c)      model = 0;
    else if (p) model = 15;
    else if (l) model = busexp;
    @(negedge clk);
    compare(req);
  endtask

  // Mid-low-phase override change, checked before any edge.
  task automatic async_ovr(input string req, input logic c, input logic p);
    @(negedge clk);
    #(CLK_PERIOD/4);
    clr = c; pre = p;
    if (c) model = 0; else if (p) model = 15;
    #1;
    compare(req);
  endtask

  initial begin
    // reset state
    step("R3", 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'h0);
    step("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    // captures from the other driver while own drivers are off
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'hA);
    step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'h5);
    step("R2", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hF);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h3);
    step("R8", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 4'hC);
    // own drive onto the bus
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    step("R7", 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h9);
    step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    // asynchronous overrides
    async_ovr("R4", 1'b0, 1'b1);
    step("R4", 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 4'h2);
    async_ovr("R5", 1'b1, 1'b1);
    step("R5", 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 4'h7);
    step("R3", 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 4'h6);
    step("R2", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'h6);
    async_ovr("R3", 1'b1, 1'b0);
    step("R3", 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 4'h0);
    // sweep of captured values
    for (int k = 0; k < 16; k++) begin
      step("R1", 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 4'(k));
      step("R7", 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 4'h0);
    end
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule